// File: doc/BRIEF.md
# Five-Phase Multi-Cycle Load/Store Core

This block is a small load/store processor. Each instruction moves through five phases, one clock per phase: fetch, decode with operand read, execute, memory, and write-back. The next instruction starts only when the current one has finished, so every completed instruction takes exactly five cycles. The core holds three storage arrays. The first is a 32-entry by 8-bit register file. The second is a 32-word instruction store with 21-bit words. The third is a 32-word by 8-bit data store. Both stores take 5-bit word addresses. A single adder serves every arithmetic need: sums, differences, immediates and effective addresses.

Programs and data are placed through a plain write port (`ld_en`, `ld_sel`, `ld_addr`, `ld_data`) while reset is held. Results are observed through two combinational peek ports, one into the register file and one into the data store, and through the program counter output. The core has no streaming data path, so no pin uses a valid/ready handshake. `instr_done` marks the write-back cycle of each instruction. `halt` goes high once a halt word has been decoded and stays high until reset.

Top module: `risc5_core`

## Requirements
- R1: After reset is released, phases follow fetch, decode, execute, memory, write-back and then fetch again, one per clock. `instr_done` is high for exactly the write-back cycle, which is the fourth cycle after the fetch edge, so pulses arrive every 5 cycles.
- R2: An instruction word holds the opcode in bits [20:15], field A in [14:10], field B in [9:5] and field C in [4:0].
- R3: Opcode 000111 writes reg[A] = reg[B] + reg[C] mod 256. The destination changes only at the edge that ends write-back.
- R4: Opcode 001000 writes reg[A] = reg[B] - reg[C] mod 256. It uses the same adder, with the second operand inverted and a carry-in of 1.
- R5: Opcode 000001 writes the low 8 bits of the 10-bit value {B,C} to reg[A].
- R6: Opcode 111001 writes reg[A] to data word (reg[B] + C) mod 32 during the memory phase. It writes no register.
- R7: Opcode 111000 writes reg[A] = data word (reg[B] + C) mod 32.
- R8: Opcode 100001 loads the program counter with C at the end of execute when reg[A] is nonzero. Otherwise fetch continues at the next word.
- R9: Opcode 111111 raises `halt` after its decode phase. The core then stays there with a frozen program counter and no further `instr_done` until reset.
- R10: A synchronous active-high reset sets the program counter to 0 and the phase to fetch, and leaves both stores and the register file unchanged.
- R11: Any other opcode writes neither registers nor memory and still takes five cycles.
- R12: The program counter increments during fetch and wraps from 31 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Store write strobe from the loader |
| ld_sel | input | 1 | 0 selects the instruction store, 1 selects the data store |
| ld_addr | input | 5 | Loader word address |
| ld_data | input | 21 | Loader data; the data store takes bits [7:0] |
| dbg_reg_sel | input | 5 | Register peek index |
| dbg_reg_val | output | 8 | Register peek value |
| dbg_mem_addr | input | 5 | Data store peek address |
| dbg_mem_val | output | 8 | Data store peek value |
| pc_out | output | 5 | Program counter |
| instr_done | output | 1 | High during each write-back cycle |
| halt | output | 1 | High once a halt word has been decoded |

## Verification
The phase and program-counter properties assume that the loader is used only while reset is held, so a core-side memory write never collides with a loader write. They also assume that programs read only registers they have written, since the register file has no reset value. The bench loads every program with reset asserted. Each program first sets the registers it later reads, using immediate moves, before any arithmetic, store or branch uses them.

// File: rtl/risc5_pkg.sv
`timescale 1ns/1ps
package risc5_pkg;
  localparam int OPW = 6;

  typedef enum logic [OPW-1:0] {
    OP_MOV  = 6'b000001,
    OP_ADD  = 6'b000111,
    OP_SUB  = 6'b001000,
    OP_BNZ  = 6'b100001,
    OP_LD   = 6'b111000,
    OP_ST   = 6'b111001,
    OP_HALT = 6'b111111
  } opcode_e;

  typedef enum logic [2:0] {
    PH_IF, PH_ID, PH_EX, PH_MEM, PH_WB, PH_HALT
  } phase_e;
endpackage

// File: rtl/risc5_ram.sv
`timescale 1ns/1ps
// Single write port, NRD asynchronous read ports; no reset on contents.
module risc5_ram #(
  parameter int W   = 8,
  parameter int AW  = 5,
  parameter int NRD = 2
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [W-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end
endmodule

// File: rtl/risc5_alu.sv
`timescale 1ns/1ps
// One adder; subtraction = invert second operand and carry in 1.
module risc5_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] y
);
  logic [DW-1:0] b_eff;
  assign b_eff = b ^ {DW{sub}};
  assign y     = a + b_eff + DW'(sub);

  always_comb begin
    a_r4_sub_equiv: assert (y == (sub ? DW'(a - b) : DW'(a + b)));
  end
endmodule

// File: rtl/risc5_decode.sv
`timescale 1ns/1ps
module risc5_decode
  import risc5_pkg::*;
#(
  parameter int RW = 5,
  parameter int DW = 8,
  parameter int IW = OPW + 3*RW
) (
  input  logic [IW-1:0] ir,
  output logic [RW-1:0] fa,
  output logic [RW-1:0] fb,
  output logic [RW-1:0] fc,
  output logic [RW-1:0] rsb_idx,
  output logic [DW-1:0] imm,
  output logic          use_imm,
  output logic          zero_a,
  output logic          alu_sub,
  output logic          reg_we,
  output logic          wb_mem,
  output logic          mem_we,
  output logic          mem_rd,
  output logic          is_bnz,
  output logic          is_halt
);
  localparam int IMMW = 2*RW;
  logic [OPW-1:0]  op;
  logic [IMMW-1:0] imm_wide;

  assign op       = ir[IW-1 -: OPW];
  assign fa       = ir[3*RW-1 -: RW];
  assign fb       = ir[2*RW-1 -: RW];
  assign fc       = ir[RW-1:0];
  assign imm_wide = {fb, fc};

  always_comb begin
    use_imm = 1'b0; zero_a = 1'b0; alu_sub = 1'b0; reg_we = 1'b0;
    wb_mem  = 1'b0; mem_we = 1'b0; mem_rd  = 1'b0; is_bnz = 1'b0;
    is_halt = 1'b0;
    rsb_idx = fc;
    imm     = DW'(fc);
    case (op)
      OP_ADD:  reg_we = 1'b1;
      OP_SUB:  begin reg_we = 1'b1; alu_sub = 1'b1; end
      OP_MOV:  begin reg_we = 1'b1; use_imm = 1'b1; zero_a = 1'b1; imm = DW'(imm_wide); end
      OP_LD:   begin reg_we = 1'b1; use_imm = 1'b1; mem_rd = 1'b1; wb_mem = 1'b1; end
      OP_ST:   begin use_imm = 1'b1; mem_we = 1'b1; rsb_idx = fa; end
      OP_BNZ:  begin is_bnz = 1'b1; rsb_idx = fa; end
      OP_HALT: is_halt = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/risc5_core.sv
`timescale 1ns/1ps
module risc5_core
  import risc5_pkg::*;
#(
  parameter int AW = 5,
  parameter int RW = 5,
  parameter int DW = 8,
  parameter int IW = OPW + 3*RW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic          ld_sel,
  input  logic [AW-1:0] ld_addr,
  input  logic [IW-1:0] ld_data,
  input  logic [RW-1:0] dbg_reg_sel,
  output logic [DW-1:0] dbg_reg_val,
  input  logic [AW-1:0] dbg_mem_addr,
  output logic [DW-1:0] dbg_mem_val,
  output logic [AW-1:0] pc_out,
  output logic          instr_done,
  output logic          halt
);
  phase_e        phase;
  logic [AW-1:0] pc;
  logic [IW-1:0] ir;
  logic [DW-1:0] a_q, b_q, alu_q, mdr_q;

  logic [RW-1:0] fa, fb, fc, rsb_idx;
  logic [DW-1:0] imm, alu_a, alu_b, alu_y;
  logic use_imm, zero_a, alu_sub, reg_we, wb_mem, mem_we, mem_rd, is_bnz, is_halt;

  logic [0:0][AW-1:0] im_ra;
  logic [0:0][IW-1:0] im_rd;
  logic [2:0][RW-1:0] rf_ra;
  logic [2:0][DW-1:0] rf_rd;
  logic [1:0][AW-1:0] dm_ra;
  logic [1:0][DW-1:0] dm_rd;
  logic               rf_we, dm_we;
  logic [AW-1:0]      dm_wa;
  logic [DW-1:0]      dm_wd, rf_wd;

  risc5_decode #(.RW(RW), .DW(DW), .IW(IW)) u_dec (
    .ir(ir), .fa(fa), .fb(fb), .fc(fc), .rsb_idx(rsb_idx), .imm(imm),
    .use_imm(use_imm), .zero_a(zero_a), .alu_sub(alu_sub), .reg_we(reg_we),
    .wb_mem(wb_mem), .mem_we(mem_we), .mem_rd(mem_rd), .is_bnz(is_bnz),
    .is_halt(is_halt)
  );

  assign alu_a = zero_a  ? '0  : a_q;
  assign alu_b = use_imm ? imm : b_q;

  risc5_alu #(.DW(DW)) u_alu (.a(alu_a), .b(alu_b), .sub(alu_sub), .y(alu_y));

  // Instruction store: loader only.
  assign im_ra[0] = pc;
  risc5_ram #(.W(IW), .AW(AW), .NRD(1)) u_imem (
    .clk(clk), .we(ld_en && !ld_sel), .waddr(ld_addr), .wdata(ld_data),
    .raddr(im_ra), .rdata(im_rd)
  );

  // Register file: operand B-field, second operand, peek.
  assign rf_ra[0] = fb;
  assign rf_ra[1] = rsb_idx;
  assign rf_ra[2] = dbg_reg_sel;
  assign rf_we    = (phase == PH_WB) && reg_we;
  assign rf_wd    = wb_mem ? mdr_q : alu_q;
  risc5_ram #(.W(DW), .AW(RW), .NRD(3)) u_rf (
    .clk(clk), .we(rf_we), .waddr(fa), .wdata(rf_wd),
    .raddr(rf_ra), .rdata(rf_rd)
  );

  // Data store: core in memory phase, loader otherwise.
  assign dm_ra[0] = alu_q[AW-1:0];
  assign dm_ra[1] = dbg_mem_addr;
  assign dm_we    = (ld_en && ld_sel) || ((phase == PH_MEM) && mem_we);
  assign dm_wa    = ld_en ? ld_addr : alu_q[AW-1:0];
  assign dm_wd    = ld_en ? ld_data[DW-1:0] : b_q;
  risc5_ram #(.W(DW), .AW(AW), .NRD(2)) u_dmem (
    .clk(clk), .we(dm_we), .waddr(dm_wa), .wdata(dm_wd),
    .raddr(dm_ra), .rdata(dm_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IF;
      pc    <= '0;
      ir    <= '0;
      a_q   <= '0;
      b_q   <= '0;
      alu_q <= '0;
      mdr_q <= '0;
    end else begin
      unique case (phase)
        PH_IF: begin
          ir    <= im_rd[0];
          pc    <= pc + 1'b1;
          phase <= PH_ID;
        end
        PH_ID: begin
          a_q   <= rf_rd[0];
          b_q   <= rf_rd[1];
          phase <= is_halt ? PH_HALT : PH_EX;
        end
        PH_EX: begin
          alu_q <= alu_y;
          if (is_bnz && (b_q != '0)) pc <= AW'(fc);
          phase <= PH_MEM;
        end
        PH_MEM: begin
          if (mem_rd) mdr_q <= dm_rd[0];
          phase <= PH_WB;
        end
        PH_WB:   phase <= PH_IF;
        default: phase <= PH_HALT;
      endcase
    end
  end

  assign pc_out      = pc;
  assign instr_done  = (phase == PH_WB);
  assign halt        = (phase == PH_HALT);
  assign dbg_reg_val = rf_rd[2];
  assign dbg_mem_val = dm_rd[1];

  // R1: phase order
  a_r1_if_id:  assert property (@(posedge clk) disable iff (rst) phase == PH_IF  |=> phase == PH_ID);
  a_r1_ex_mem: assert property (@(posedge clk) disable iff (rst) phase == PH_EX  |=> phase == PH_MEM);
  a_r1_mem_wb: assert property (@(posedge clk) disable iff (rst) phase == PH_MEM |=> phase == PH_WB);
  a_r1_wb_if:  assert property (@(posedge clk) disable iff (rst) instr_done |=> phase == PH_IF && !instr_done);
  // R12: fetch advances pc with wrap
  a_r12_pc_step: assert property (@(posedge clk) disable iff (rst)
    phase == PH_IF |=> pc == AW'($past(pc) + 1'b1));
  // R8: pc only moves in fetch or execute
  a_r8_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ID || phase == PH_MEM || phase == PH_WB) |=> $stable(pc));
  // R9: halt is sticky and quiet
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt && !instr_done && $stable(pc));
endmodule

// File: tb/sim_risc5_core.sv
`timescale 1ns/1ps
module sim_risc5_core;
  localparam logic [5:0] MOV = 6'b000001, ADD = 6'b000111, SUB = 6'b001000,
                         BNZ = 6'b100001, LDW = 6'b111000, STW = 6'b111001,
                         HLT = 6'b111111, BAD = 6'b010101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0, ld_sel = 1'b0;
  logic [4:0] ld_addr = '0;
  logic [20:0] ld_data = '0;
  logic [4:0] dbg_reg_sel = '0, dbg_mem_addr = '0;
  logic [7:0] dbg_reg_val, dbg_mem_val;
  logic [4:0] pc_out;
  logic instr_done, halt;

  int checks = 0, errors = 0, dones = 0, cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  risc5_core u0 (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
    .dbg_mem_addr(dbg_mem_addr), .dbg_mem_val(dbg_mem_val), .pc_out(pc_out),
    .instr_done(instr_done), .halt(halt)
  );

  // Stimulus table: {opcode, a, b, expected}
  localparam logic [29:0] VEC [6] = '{
    {ADD, 8'h2A, 8'h12, 8'h3C},
    {ADD, 8'hFF, 8'h01, 8'h00},
    {ADD, 8'h80, 8'h80, 8'h00},
    {SUB, 8'h3C, 8'h12, 8'h2A},
    {SUB, 8'h00, 8'h01, 8'hFF},
    {SUB, 8'h55, 8'h55, 8'h00}
  };

  function automatic logic [20:0] enc(logic [5:0] op, logic [4:0] a, logic [4:0] b, logic [4:0] c);
    return {op, a, b, c};
  endfunction

  function automatic logic [20:0] movi(logic [4:0] rd, logic [7:0] v);
    return {MOV, rd, 2'b00, v[7:5], v[4:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(bit sel, logic [4:0] addr, logic [20:0] data);
    ld_en = 1'b1; ld_sel = sel; ld_addr = addr; ld_data = data;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic hold_reset();
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_to_halt();
    dones = 0; cyc = 0;
    rst = 1'b0;
    while (!halt && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (instr_done) dones++;
    end
  endtask

  function automatic logic [7:0] peek_reg(logic [4:0] r);
    return 8'h00;
  endfunction

  task automatic reg_is(string req, logic [4:0] r, logic [7:0] exp);
    dbg_reg_sel = r; #0.1;
    chk(req, {24'h0, dbg_reg_val}, {24'h0, exp});
  endtask

  task automatic mem_is(string req, logic [4:0] a, logic [7:0] exp);
    dbg_mem_addr = a; #0.1;
    chk(req, {24'h0, dbg_mem_val}, {24'h0, exp});
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R10: reset state
    chk("R10 reset pc", {27'h0, pc_out}, 32'h0);
    chk("R10 reset halt", {31'h0, halt}, 32'h0);
    chk("R10 reset done", {31'h0, instr_done}, 32'h0);

    // R3/R4 (R2 field layout): table walk
    for (int i = 0; i < 6; i++) begin
      hold_reset();
      put(0, 5'd0, movi(5'd2, VEC[i][23:16]));
      put(0, 5'd1, movi(5'd3, VEC[i][15:8]));
      put(0, 5'd2, enc(VEC[i][29:24], 5'd1, 5'd2, 5'd3));
      put(0, 5'd3, enc(HLT, 0, 0, 0));
      run_to_halt();
      reg_is((VEC[i][29:24] == ADD) ? "R3 add" : "R4 sub", 5'd1, VEC[i][7:0]);
    end

    // R1 timing and R3 write-back edge; R5 immediate truncation
    hold_reset();
    put(0, 5'd0, movi(5'd5, 8'h09));
    put(0, 5'd1, enc(MOV, 5'd5, 5'b11000, 5'b00111)); // {B,C}=0x307 -> 0x07
    put(0, 5'd2, enc(HLT, 0, 0, 0));
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 no done before write-back", {31'h0, instr_done}, 32'h0);
    @(negedge clk);
    chk("R1 done on 4th cycle", {31'h0, instr_done}, 32'h1);
    @(negedge clk);
    chk("R1 done single cycle", {31'h0, instr_done}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R1 second done spacing", {31'h0, instr_done}, 32'h0);
    @(negedge clk);
    chk("R1 second done after 5", {31'h0, instr_done}, 32'h1);
    reg_is("R3 dest unchanged during write-back", 5'd5, 8'h09);
    @(negedge clk);
    reg_is("R5 low 8 bits of immediate", 5'd5, 8'h07);

    // R6/R7 store and load, address wrap
    hold_reset();
    put(0, 5'd0, movi(5'd4, 8'h03));
    put(0, 5'd1, movi(5'd1, 8'h5A));
    put(0, 5'd2, enc(STW, 5'd1, 5'd4, 5'd2));      // dmem[5]=5A
    put(0, 5'd3, movi(5'd0, 8'h00));
    put(0, 5'd4, enc(LDW, 5'd7, 5'd0, 5'd5));      // r7=dmem[5]
    put(0, 5'd5, movi(5'd8, 8'hFE));
    put(0, 5'd6, movi(5'd9, 8'hC3));
    put(0, 5'd7, enc(STW, 5'd9, 5'd8, 5'd3));      // (FE+3)%32=1
    put(0, 5'd8, enc(LDW, 5'd10, 5'd8, 5'd4));     // (FE+4)%32=2
    put(0, 5'd9, enc(HLT, 0, 0, 0));
    put(1, 5'd2, 21'h0000E7);
    run_to_halt();
    mem_is("R6 store base+offset", 5'd5, 8'h5A);
    reg_is("R6 store writes no register", 5'd1, 8'h5A);
    reg_is("R7 load", 5'd7, 8'h5A);
    mem_is("R6 store address wraps", 5'd1, 8'hC3);
    reg_is("R7 load address wraps", 5'd10, 8'hE7);

    // R10: reset keeps memory and registers
    hold_reset();
    hold_reset();
    chk("R10 pc cleared", {27'h0, pc_out}, 32'h0);
    mem_is("R10 data store kept", 5'd5, 8'h5A);
    reg_is("R10 registers kept", 5'd7, 8'h5A);

    // R8 branch taken / not taken; R9 halt
    hold_reset();
    put(0, 5'd0, movi(5'd2, 8'h11));
    put(0, 5'd1, movi(5'd1, 8'h01));
    put(0, 5'd2, enc(BNZ, 5'd1, 5'd0, 5'd5));
    put(0, 5'd3, movi(5'd2, 8'hAA));
    put(0, 5'd4, enc(HLT, 0, 0, 0));
    put(0, 5'd5, movi(5'd3, 8'h33));
    put(0, 5'd6, movi(5'd11, 8'h00));
    put(0, 5'd7, enc(BNZ, 5'd11, 5'd0, 5'd3));
    put(0, 5'd8, movi(5'd12, 8'h44));
    put(0, 5'd9, enc(HLT, 0, 0, 0));
    run_to_halt();
    reg_is("R8 taken branch skips", 5'd2, 8'h11);
    reg_is("R8 target executed", 5'd3, 8'h33);
    reg_is("R8 not taken falls through", 5'd12, 8'h44);
    chk("R9 halt pc", {27'h0, pc_out}, 32'd10);
    chk("R9 completed count", dones, 7);
    dones = 0;
    repeat (20) begin
      @(negedge clk);
      if (instr_done) dones++;
    end
    chk("R9 halt sticky", {31'h0, halt}, 32'h1);
    chk("R9 no done while halted", dones, 0);
    chk("R9 pc frozen", {27'h0, pc_out}, 32'd10);

    // R11 unknown opcode
    hold_reset();
    put(0, 5'd0, movi(5'd1, 8'h77));
    put(0, 5'd1, enc(BAD, 5'd1, 5'd1, 5'd1));
    put(0, 5'd2, movi(5'd13, 8'h66));
    put(0, 5'd3, enc(HLT, 0, 0, 0));
    put(1, 5'd1, 21'h0000C3);
    run_to_halt();
    reg_is("R11 unknown writes no register", 5'd1, 8'h77);
    mem_is("R11 unknown writes no memory", 5'd1, 8'hC3);
    reg_is("R11 next instruction runs", 5'd13, 8'h66);
    chk("R11 unknown takes five cycles", dones, 3);

    // R12 pc wrap 31 -> 0
    hold_reset();
    put(0, 5'd0, movi(5'd14, 8'h00));
    put(0, 5'd1, enc(HLT, 0, 0, 0));
    run_to_halt();
    hold_reset();
    put(0, 5'd0, enc(BNZ, 5'd14, 5'd0, 5'd3));
    put(0, 5'd1, movi(5'd14, 8'h01));
    put(0, 5'd2, enc(BNZ, 5'd14, 5'd0, 5'd30));
    put(0, 5'd3, enc(HLT, 0, 0, 0));
    put(0, 5'd30, movi(5'd10, 8'h21));
    put(0, 5'd31, movi(5'd11, 8'h22));
    run_to_halt();
    reg_is("R12 word 31 executed", 5'd11, 8'h22);
    chk("R12 wrapped to 0 then branched", {27'h0, pc_out}, 32'd4);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule